// File: doc/BRIEF.md
# Counted Loop Branch Unit

This block resolves the program counter for two kinds of relative control transfer. The first is a counted loop: it decrements a 32-bit count register and branches back while the count has not reached zero. The second is an unconditional relative jump. The branch target is the address of the instruction that follows the branch, plus a signed 8-bit displacement. When no branch is taken, the next program counter is that following address.

A decode stage presents the current instruction address, the instruction length in bytes, the displacement byte and an operation code, and pulses a start strobe for one cycle. One cycle later the unit presents the resolved next program counter, a taken flag and a result-valid pulse. The count register is also visible on an output. A separate write port loads the count register so that software can set up a loop. The count moves in the same cycle as the branch decision, so a loop body can issue back-to-back loop operations.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, nextPc is 0, taken is 0, count is 0 and resultValid is 0.
- R2: A start with opSel = 2'b01 (loop) decrements count by exactly one. The new value appears on count in the cycle after the start.
- R3: For a loop operation, taken is 1 exactly when the decremented count is nonzero. In that case nextPc = instAddr + instLen + sign-extended relOffset.
- R4: For a loop operation whose decremented count is zero, taken is 0 and nextPc = instAddr + instLen.
- R5: A loop operation that starts with count = 0 wraps count to 32'hFFFF_FFFF and is taken.
- R6: relOffset is a two's-complement byte. A value of 8'h80 reaches 128 bytes back from the following instruction, and 8'h7F reaches 127 bytes forward. With a following address of 32'h0E, the value 8'hFC gives a target of 32'h0A.
- R7: A start with opSel = 2'b10 (jump) is always taken, loads nextPc with the relative target, and leaves count unchanged.
- R8: A start with opSel = 2'b00 or 2'b11 (step) gives taken = 0 and nextPc = instAddr + instLen, and leaves count unchanged.
- R9: When cntWrEn is high and no loop operation starts in that cycle, count takes cntWrData in the next cycle.
- R10: When cntWrEn is high in the same cycle as a loop start, the write is dropped and the loop decrement is applied.
- R11: resultValid is high exactly in the cycle after each start. When there is no start, nextPc and taken hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle request to resolve a branch |
| opSel | input | 2 | 01 loop, 10 jump, 00/11 step |
| instAddr | input | 32 | Address of the current instruction |
| instLen | input | 4 | Length of the current instruction in bytes |
| relOffset | input | 8 | Signed displacement from the following instruction |
| cntWrEn | input | 1 | Count register write enable |
| cntWrData | input | 32 | Value to load into the count register |
| nextPc | output | 32 | Resolved next program counter |
| taken | output | 1 | High when the branch target was selected |
| count | output | 32 | Current count register value |
| resultValid | output | 1 | High in the cycle after a start |

## Verification
The hardest condition to reach from the ports is the loop that begins at a zero count and wraps to all ones. Random write data almost never lands on zero or one. The stimulus therefore biases count loads toward 0, 1 and 2, which puts the wrap and the final not-taken iteration at the boundary. It also issues a loop in the same cycle as a counter write, to exercise the drop rule. Directed steps cover the two extreme displacement bytes and the worked target example.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [1:0] {
    OP_STEP     = 2'b00,
    OP_LOOP     = 2'b01,
    OP_JUMP     = 2'b10,
    OP_STEP_ALT = 2'b11
  } opSel_e;

  typedef struct packed {
    logic issue;
    logic decCnt;
    logic loadCnt;
    logic condBranch;
    logic forceBranch;
  } lbuStrobe_t;

endpackage

// File: rtl/lbu_ctrl.sv
module lbu_ctrl
  import lbu_pkg::*;
(
  input  logic       startValid,
  input  logic [1:0] opSel,
  input  logic       cntWrEn,
  output lbuStrobe_t strobes
);

  opSel_e opCode;
  logic   isLoop;

  assign opCode = opSel_e'(opSel);
  assign isLoop = startValid && (opCode == OP_LOOP);

  always_comb begin
    strobes             = '0;
    strobes.issue       = startValid;
    strobes.decCnt      = isLoop;
    strobes.condBranch  = isLoop;
    strobes.forceBranch = startValid && (opCode == OP_JUMP);
    // a loop in flight owns the counter; a simultaneous write is dropped
    strobes.loadCnt     = cntWrEn && !isLoop;
  end

endmodule

// File: rtl/lbu_datapath.sv
module lbu_datapath
  import lbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbuStrobe_t        strobes,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [OFS_W-1:0]  relOffset,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic [CNT_W-1:0]  count,
  output logic              resultValid
);

  localparam int OFS_PAD = ADDR_W - OFS_W;
  localparam int LEN_PAD = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] ofsExt;
  logic [ADDR_W-1:0] targetAddr;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  countDec;
  logic              loopGo;
  logic              branchNow;
  logic [ADDR_W-1:0] nextPcQ;
  logic              takenQ;
  logic              validQ;

  assign seqAddr    = instAddr + {{LEN_PAD{1'b0}}, instLen};
  assign ofsExt     = {{OFS_PAD{relOffset[OFS_W-1]}}, relOffset};
  assign targetAddr = seqAddr + ofsExt;

  assign countDec   = countQ - {{(CNT_W-1){1'b0}}, 1'b1};
  assign loopGo     = |countDec;
  assign branchNow  = strobes.forceBranch || (strobes.condBranch && loopGo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      nextPcQ <= '0;
      takenQ  <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobes.issue;
      if (strobes.decCnt) begin
        countQ <= countDec;
      end else if (strobes.loadCnt) begin
        countQ <= cntWrData;
      end
      if (strobes.issue) begin
        takenQ  <= branchNow;
        nextPcQ <= branchNow ? targetAddr : seqAddr;
      end
    end
  end

  assign nextPc      = nextPcQ;
  assign taken       = takenQ;
  assign count       = countQ;
  assign resultValid = validQ;

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        opSel,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [OFS_W-1:0]  relOffset,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic [CNT_W-1:0]  count,
  output logic              resultValid
);

  lbuStrobe_t strobes;

  lbu_ctrl u_ctrl (
    .startValid (startValid),
    .opSel      (opSel),
    .cntWrEn    (cntWrEn),
    .strobes    (strobes)
  );

  lbu_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .OFS_W  (OFS_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .instAddr    (instAddr),
    .instLen     (instLen),
    .relOffset   (relOffset),
    .cntWrData   (cntWrData),
    .nextPc      (nextPc),
    .taken       (taken),
    .count       (count),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 8,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [1:0]        opSel,
  input logic [ADDR_W-1:0] instAddr,
  input logic [LEN_W-1:0]  instLen,
  input logic [OFS_W-1:0]  relOffset,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData,
  input logic [ADDR_W-1:0] nextPc,
  input logic              taken,
  input logic [CNT_W-1:0]  count,
  input logic              resultValid
);

  logic [ADDR_W-1:0] seqChk;
  assign seqChk = instAddr + ADDR_W'(instLen);

  a_r2_loop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSel == 2'b01) |=> (count == $past(count) - CNT_W'(1)));

  a_r3_taken_when_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSel == 2'b01) |=> (taken == (count != '0)));

  a_r7_jump_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSel == 2'b10 && !cntWrEn) |=> (taken && $stable(count)));

  a_r8_step_sequential: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && opSel[1] == opSel[0]) |=> (!taken && nextPc == $past(seqChk)));

  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && !(startValid && opSel == 2'b01)) |=> (count == $past(cntWrData)));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> resultValid);

  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> (!resultValid && $stable(nextPc) && $stable(taken)));

endmodule

bind loop_branch_unit lbu_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .OFS_W  (OFS_W),
  .LEN_W  (LEN_W)
) u_lbu_checker (
  .clk         (clk),
  .rstN        (rstN),
  .startValid  (startValid),
  .opSel       (opSel),
  .instAddr    (instAddr),
  .instLen     (instLen),
  .relOffset   (relOffset),
  .cntWrEn     (cntWrEn),
  .cntWrData   (cntWrData),
  .nextPc      (nextPc),
  .taken       (taken),
  .count       (count),
  .resultValid (resultValid)
);

// File: tb/loop_branch_unit_bench.sv
`timescale 1ns/1ps
module loop_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] instAddr = '0;
  logic [3:0]  instLen = '0;
  logic [7:0]  relOffset = '0;
  logic        cntWrEn = 1'b0;
  logic [31:0] cntWrData = '0;
  logic [31:0] nextPc;
  logic        taken;
  logic [31:0] count;
  logic        resultValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mCount = '0;
  logic [31:0] mPc = '0;
  logic        mTaken = 1'b0;

  always #2.5 clk = ~clk;

  loop_branch_unit u_loop_branch_unit (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opSel(opSel),
    .instAddr(instAddr), .instLen(instLen), .relOffset(relOffset),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .nextPc(nextPc),
    .taken(taken), .count(count), .resultValid(resultValid)
  );

  function automatic logic [31:0] relTarget(input logic [31:0] a, input logic [3:0] l,
                                            input logic [7:0] o);
    return a + 32'(l) + {{24{o[7]}}, o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs at the following negedge
  task automatic cycle(input string req, input bit st, input logic [1:0] op,
                       input logic [31:0] a, input logic [3:0] l, input logic [7:0] o,
                       input bit wr, input logic [31:0] wd);
    logic [31:0] seq;
    logic [31:0] tgt;
    @(negedge clk);
    startValid = st; opSel = op; instAddr = a; instLen = l; relOffset = o;
    cntWrEn = wr; cntWrData = wd;
    seq = a + 32'(l);
    tgt = relTarget(a, l, o);
    if (st && op == 2'b01) begin
      mCount = mCount - 1;
      mTaken = (mCount != 0);
      mPc = mTaken ? tgt : seq;
    end else begin
      if (wr) mCount = wd;
      if (st && op == 2'b10) begin
        mTaken = 1'b1; mPc = tgt;
      end else if (st) begin
        mTaken = 1'b0; mPc = seq;
      end
    end
    @(negedge clk);
    startValid = 1'b0; cntWrEn = 1'b0;
    check({req, " valid"}, 32'(resultValid), 32'(st));
    check({req, " pc"}, nextPc, mPc);
    check({req, " taken"}, 32'(taken), 32'(mTaken));
    check({req, " count"}, count, mCount);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedSink;
    seedSink = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 pc", nextPc, 32'h0);
    check("R1 taken", 32'(taken), 32'h0);
    check("R1 count", count, 32'h0);
    check("R1 valid", 32'(resultValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count after", count, 32'h0);

    // R9 load, then R2/R3/R4/R6 with worked example (0x0C + 2 = 0x0E, FC -> 0x0A)
    cycle("R9 load", 0, 2'b00, 0, 0, 0, 1, 32'd3);
    cycle("R3 R6 loop1", 1, 2'b01, 32'h0C, 4'd2, 8'hFC, 0, 0);
    check("R6 example target", nextPc, 32'h0A);
    cycle("R2 loop2", 1, 2'b01, 32'h0C, 4'd2, 8'hFC, 0, 0);
    cycle("R4 loop3", 1, 2'b01, 32'h0C, 4'd2, 8'hFC, 0, 0);
    check("R4 fallthrough", nextPc, 32'h0E);
    // R5 wrap from zero
    cycle("R5 wrap", 1, 2'b01, 32'h100, 4'd2, 8'hF0, 0, 0);
    check("R5 wrap count", count, 32'hFFFF_FFFF);
    // R6 extremes
    cycle("R6 back128", 1, 2'b01, 32'h1000, 4'd2, 8'h80, 0, 0);
    check("R6 back128 pc", nextPc, 32'h0F82);
    cycle("R6 fwd127", 1, 2'b01, 32'h1000, 4'd2, 8'h7F, 0, 0);
    check("R6 fwd127 pc", nextPc, 32'h1081);
    // R7 jump with zero count keeps count
    cycle("R9 load0", 0, 2'b00, 0, 0, 0, 1, 32'd0);
    cycle("R7 jump", 1, 2'b10, 32'h2000, 4'd3, 8'h10, 0, 0);
    // R8 step encodings
    cycle("R8 step00", 1, 2'b00, 32'h3000, 4'd5, 8'h20, 0, 0);
    cycle("R8 step11", 1, 2'b11, 32'h3100, 4'd7, 8'h20, 0, 0);
    // R10 write dropped under loop
    cycle("R9 load5", 0, 2'b00, 0, 0, 0, 1, 32'd5);
    cycle("R10 drop", 1, 2'b01, 32'h40, 4'd2, 8'hF8, 1, 32'hABCD);
    check("R10 count", count, 32'd4);
    // R11 idle holds
    cycle("R11 idle", 0, 2'b10, 32'h9999, 4'd1, 8'h01, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      int pick;
      pick = $urandom_range(0, 3);
      wd = (pick == 3) ? $urandom() : 32'(pick);
      cycle($sformatf("R3 R7 R8 R9 R10 rnd%0d", i), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), $urandom(), 4'($urandom_range(1, 15)),
            8'($urandom()), ($urandom_range(0, 3) == 0), wd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule